// File: doc/BRIEF.md
# Ethernet PHY Clock Generator

This block makes the clocks that run between an Ethernet MAC and its PHY. It is set up through one configuration word. The block picks one of two source clocks, divides that source by a programmable integer, and then divides again by 5 or 10 to make the PHY reference clock. From the same counter chain it makes a transmit clock, which can be delayed in quarter-period steps. It also makes a reduced-pin-count interface clock, which can be inverted. One bit enables all of these outputs together.

The whole design runs on one fast system clock, so it stays in a single domain. Each source arrives as a clock-enable strobe: one system-clock pulse per source period. Each output is a registered level on the system clock. A new configuration word is applied as a whole, and only at a reference-period boundary. So a change never cuts an output phase short.

Top module: `eth_phy_clkgen`

## Requirements
- R1: A write stores the whole configuration word. The word reads back on `cfgRdata` from the cycle after the write. After reset the word is 0.
- R2: Bit 4 picks the source. 0 counts `srcStbA` strobes and 1 counts `srcStbB` strobes.
- R3: Bits 9:7 hold the first divisor N, where N equals the field value. A field of 0 divides by 1, exactly as a field of 1 does.
- R4: Bit 10 sets the second ratio M: 0 gives 5 and 1 gives 10. With a source period of P system clocks, `refClk` has a period of P·N·M cycles. It stays high for P·N·ceil(M/2) of those cycles, so an odd ratio has a high phase one stage-one period longer than its low phase.
- R5: Bit 0 sets the interface mode: 1 is RGMII and 0 is RMII. In RGMII mode, bits 6:5 give the delay code d. The rising edge of `txClk` then follows the rising edge of `refClk` by floor(d·M/4) stage-one periods, which is floor(d·M/4)·N·P system clocks.
- R6: In RMII mode (bit 0 = 0), `txClk` has no delay and equals `refClk`, whatever bits 6:5 hold.
- R7: When bit 11 is set in RMII mode, `rmiiClk` is the inverse of `refClk`. In every other enabled case, `rmiiClk` equals `refClk`.
- R8: Bit 12 enables the outputs. While the applied word has this bit clear, `refClk`, `txClk` and `rmiiClk` all stay low.
- R9: A new word is applied only when the second stage reaches its terminal count. Until then the old settings stay in force. As a result, every high or low phase of `refClk` has either the old length or the new length, and none is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and outputs run on it |
| rstN | input | 1 | Active-low synchronous reset |
| srcStbA | input | 1 | First source, one pulse per source period |
| srcStbB | input | 1 | Second source, one pulse per source period |
| cfgWe | input | 1 | Write strobe for the configuration word |
| cfgWdata | input | REG_W | Configuration word to write |
| cfgRdata | output | REG_W | Stored configuration word |
| refClk | output | 1 | PHY reference clock |
| txClk | output | 1 | Transmit clock with the selected phase delay |
| rmiiClk | output | 1 | Reduced-pin-count clock, inverted when selected |

## Verification
The bench measures the period, the high time and the offset from the reference edge to the transmit edge, in system clocks, for both sources and both ratios.

- **Divider field of zero.** The bench compares a field of zero against a field of one. A design that treats zero as a divisor of zero would stall the chain or wrap it to 8.
- **Delay codes.** The codes are tried at ratio 5 and at ratio 10. A wrong delay scale moves the transmit edge to a different cycle. A design that keeps the delay in RMII mode shows a non-zero offset.
- **Inversion.** Inversion is checked in both modes. A design that inverts in RGMII mode makes `rmiiClk` differ from `refClk` there.
- **Mid-phase change.** The bench rewrites the configuration in the middle of a long high phase and records the next six phase lengths. A design that applies the new settings at once would show a truncated phase.

// File: rtl/eth_clkgen_pkg.sv
package eth_clkgen_pkg;
  // bit positions in the configuration word (decoded by the control block)
  localparam int MODE_BIT  = 0;
  localparam int SEL_BIT   = 4;
  localparam int DLY_LO    = 5;
  localparam int DIV_LO    = 7;
  localparam int RATIO_BIT = 10;
  localparam int INV_BIT   = 11;
  localparam int EN_BIT    = 12;
  localparam int DIV_W     = 3;
  localparam int DLY_W     = 2;
  localparam int CFG_BITS  = EN_BIT + 1;
  localparam int RATIO_LO  = 5;
  localparam int RATIO_HI  = 10;
  localparam int CNT2_W    = $clog2(RATIO_HI);

  typedef struct packed {
    logic             rgmii;
    logic             srcSel;
    logic [DLY_W-1:0] txDly;
    logic [DIV_W-1:0] div1;
    logic             ratio10;
    logic             invRmii;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/eth_clkgen_ctrl.sv
module eth_clkgen_ctrl
  import eth_clkgen_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output ctrl_t            ctrl
);
  logic [REG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWdata;
  end

  assign cfgRdata = cfgReg;

  always_comb begin
    ctrl.rgmii   = cfgReg[MODE_BIT];
    ctrl.srcSel  = cfgReg[SEL_BIT];
    ctrl.txDly   = cfgReg[DLY_LO +: DLY_W];
    ctrl.div1    = cfgReg[DIV_LO +: DIV_W];
    ctrl.ratio10 = cfgReg[RATIO_BIT];
    ctrl.invRmii = cfgReg[INV_BIT];
    ctrl.enable  = cfgReg[EN_BIT];
  end

  // R1: written word is visible on the read port one cycle later
  assert_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata == $past(cfgWdata));
endmodule

// File: rtl/eth_clkgen_dp.sv
module eth_clkgen_dp
  import eth_clkgen_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  srcStbA,
  input  logic  srcStbB,
  input  ctrl_t ctrl,
  output logic  refClk,
  output logic  txClk,
  output logic  rmiiClk
);
  localparam int PROD_W = DLY_W + CNT2_W;

  ctrl_t             actCfg;
  logic [DIV_W-1:0]  cnt1;
  logic [CNT2_W-1:0] cnt2;
  logic [DIV_W-1:0]  divEff;
  logic [CNT2_W-1:0] ratioM, highLen, txOffset;
  logic [PROD_W-1:0] dlyProd;
  logic [CNT2_W:0]   txPhase;
  logic              selStb, tick1, wrap2, refLvl;

  assign selStb  = actCfg.srcSel ? srcStbB : srcStbA;
  assign divEff  = (actCfg.div1 == '0) ? DIV_W'(1) : actCfg.div1;
  assign tick1   = selStb && (cnt1 == divEff - DIV_W'(1));
  assign ratioM  = actCfg.ratio10 ? CNT2_W'(RATIO_HI) : CNT2_W'(RATIO_LO);
  assign highLen = actCfg.ratio10 ? CNT2_W'((RATIO_HI + 1) / 2) : CNT2_W'((RATIO_LO + 1) / 2);
  assign wrap2   = tick1 && (cnt2 == ratioM - CNT2_W'(1));

  // quarter-step offset in stage-one periods; forced to zero outside RGMII
  always_comb begin
    dlyProd  = PROD_W'(actCfg.txDly) * PROD_W'(ratioM);
    txOffset = actCfg.rgmii ? CNT2_W'(dlyProd >> 2) : '0;
    if (cnt2 >= txOffset) txPhase = {1'b0, cnt2} - {1'b0, txOffset};
    else                  txPhase = {1'b0, cnt2} + {1'b0, ratioM} - {1'b0, txOffset};
  end

  assign refLvl = cnt2 < highLen;

  // counter chain; whole configuration applied at the reference terminal count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt1   <= '0;
      cnt2   <= '0;
      actCfg <= '0;
    end else begin
      if (tick1) cnt1 <= '0;
      else if (selStb) cnt1 <= cnt1 + DIV_W'(1);
      if (wrap2) begin
        cnt2   <= '0;
        actCfg <= ctrl;
      end else if (tick1) begin
        cnt2 <= cnt2 + CNT2_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refClk  <= 1'b0;
      txClk   <= 1'b0;
      rmiiClk <= 1'b0;
    end else begin
      refClk  <= actCfg.enable && refLvl;
      txClk   <= actCfg.enable && (txPhase < {1'b0, highLen});
      rmiiClk <= actCfg.enable && ((actCfg.invRmii && !actCfg.rgmii) ? !refLvl : refLvl);
    end
  end

  // R3: stage-one count stays below the effective divisor
  assert_cnt1_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt1 < divEff);
  // R4: stage-two count stays below the active ratio
  assert_cnt2_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt2 < ratioM);
  // R9: applied settings move only at the terminal count
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrap2 |=> $stable(actCfg));
  // R8: disabled generator keeps every output low
  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !actCfg.enable |=> (!refClk && !txClk && !rmiiClk));
  // R6: RMII mode leaves transmit clock aligned with reference
  assert_rmii_nodly_R6: assert property (@(posedge clk) disable iff (!rstN)
    !actCfg.rgmii |=> txClk == refClk);
  // R7: inversion in RMII mode gives complement of reference
  assert_rmii_inv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (actCfg.enable && actCfg.invRmii && !actCfg.rgmii) |=> rmiiClk != refClk);
endmodule

// File: rtl/eth_phy_clkgen.sv
module eth_phy_clkgen
  import eth_clkgen_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcStbA,
  input  logic             srcStbB,
  input  logic             cfgWe,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output logic             refClk,
  output logic             txClk,
  output logic             rmiiClk
);
  ctrl_t ctrl;

  eth_clkgen_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .ctrl(ctrl)
  );

  eth_clkgen_dp uDp (
    .clk(clk), .rstN(rstN), .srcStbA(srcStbA), .srcStbB(srcStbB),
    .ctrl(ctrl), .refClk(refClk), .txClk(txClk), .rmiiClk(rmiiClk)
  );

  initial begin
    assert_regw_fits_R1: assert (REG_W >= CFG_BITS);
  end
endmodule

// File: tb/eth_phy_clkgen_test.sv
`timescale 1ns/1ps
module eth_phy_clkgen_test;
  localparam int REG_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcStbA = 1'b0, srcStbB = 1'b0, cfgWe = 1'b0;
  logic [REG_W-1:0] cfgWdata = '0;
  logic [REG_W-1:0] cfgRdata;
  logic refClk, txClk, rmiiClk;

  eth_phy_clkgen #(.REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .srcStbA(srcStbA), .srcStbB(srcStbB),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .refClk(refClk), .txClk(txClk), .rmiiClk(rmiiClk)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    kind;   // 0 = running, 1 = disabled
    int    per;
    int    hi;
    int    off;
    bit    inv;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, fails = 0, pushed = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // source A: period 2 cycles; source B: period 3 cycles
  initial forever begin
    @(negedge clk) srcStbA = 1'b1;
    @(negedge clk) srcStbA = 1'b0;
  end
  initial forever begin
    @(negedge clk) srcStbB = 1'b1;
    @(negedge clk) srcStbB = 1'b0;
    @(negedge clk);
  end

  function automatic logic [REG_W-1:0] mk(bit rg, bit sel, int dly, int dv, bit r10, bit inv, bit en);
    logic [REG_W-1:0] v = '0;
    v[0] = rg; v[4] = sel; v[6:5] = 2'(dly); v[9:7] = 3'(dv);
    v[10] = r10; v[11] = inv; v[12] = en;
    return v;
  endfunction

  task automatic wrCfg(input logic [REG_W-1:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
    chk(cfgRdata == v, "R1", "readback", int'(cfgRdata), int'(v));
  endtask

  task automatic runCase(input logic [REG_W-1:0] v, input int per, input int hi,
                         input int off, input bit inv, input string tag);
    exp_t e;
    wrCfg(v);
    repeat (500) @(negedge clk);
    e.kind = 0; e.per = per; e.hi = hi; e.off = off; e.inv = inv; e.tag = tag;
    expQ.push_back(e); pushed++;
    wait (done == pushed);
  endtask

  task automatic runOff(input logic [REG_W-1:0] v);
    exp_t e;
    wrCfg(v);
    repeat (500) @(negedge clk);
    e.kind = 1; e.per = 0; e.hi = 0; e.off = 0; e.inv = 0; e.tag = "R8";
    expQ.push_back(e); pushed++;
    wait (done == pushed);
  endtask

  // monitor: measure one full reference period after a rising edge
  initial begin
    exp_t e;
    forever begin
      wait (expQ.size() > 0);
      e = expQ.pop_front();
      if (e.kind == 1) begin
        int highs = 0;
        for (int i = 0; i < 300; i++) begin
          @(negedge clk);
          if (refClk || txClk || rmiiClk) highs++;
        end
        chk(highs == 0, "R8", "high samples while disabled", highs, 0);
      end else begin
        logic pr, pt;
        int k, hi, off, bad;
        pr = refClk; pt = txClk;
        forever begin
          @(negedge clk);
          if (!pr && refClk) break;
          pr = refClk; pt = txClk;
        end
        k = 0; hi = 0; off = -1; bad = 0;
        forever begin
          if (off < 0 && !pt && txClk) off = k;
          if (refClk) hi++;
          if (rmiiClk !== (e.inv ? !refClk : refClk)) bad++;
          pt = txClk; pr = refClk;
          @(negedge clk); k++;
          if (!pr && refClk) break;
        end
        chk(k == e.per, e.tag, "period", k, e.per);
        chk(hi == e.hi, e.tag, "high time", hi, e.hi);
        chk(off == e.off, e.tag, "tx offset", off, e.off);
        chk(bad == 0, "R7", "rmiiClk mismatches", bad, 0);
      end
      done++;
    end
  end

  task automatic runLen(output int len, output logic lvl);
    lvl = refClk; len = 0;
    while (refClk == lvl) begin @(negedge clk); len++; end
  endtask

  initial begin
    int len;
    logic lvl;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 R8: reset state
    chk(cfgRdata == '0, "R1", "reset word", int'(cfgRdata), 0);
    begin
      int highs = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (refClk || txClk || rmiiClk) highs++;
      end
      chk(highs == 0, "R8", "outputs after reset", highs, 0);
    end
    // R4: src A, N=1, M=5 -> period 10, high 6
    runCase(mk(1, 0, 0, 1, 0, 0, 1), 10, 6, 0, 0, "R4");
    // R3: field 0 divides by one
    runCase(mk(1, 0, 0, 0, 0, 0, 1), 10, 6, 0, 0, "R3");
    // R5: N=3, M=10, d=1 -> offset 2*3*2
    runCase(mk(1, 0, 1, 3, 1, 0, 1), 60, 30, 12, 0, "R5");
    // R2: source B, N=2, M=5, d=3 -> offset 3*6
    runCase(mk(1, 1, 3, 2, 0, 0, 1), 30, 18, 18, 0, "R2");
    // R5: source B, N=2, M=10, d=2 -> offset 5*6
    runCase(mk(1, 1, 2, 2, 1, 0, 1), 60, 30, 30, 0, "R5");
    // R6 R7: RMII mode, delay code ignored, inversion active
    runCase(mk(0, 0, 3, 2, 1, 1, 1), 40, 20, 0, 1, "R6");
    // R7: inversion bit ignored in RGMII mode
    runCase(mk(1, 0, 0, 2, 1, 1, 1), 40, 20, 0, 0, "R7");
    // R4 R5: N=7, M=10, source B, d=3 -> offset 7*3*7
    runCase(mk(1, 1, 3, 7, 1, 0, 1), 210, 105, 147, 0, "R4");
    // R9: change in mid-high phase; every phase is old or new length
    @(negedge clk);
    while (refClk) @(negedge clk);
    while (!refClk) @(negedge clk);
    repeat (20) @(negedge clk);
    wrCfg(mk(1, 0, 0, 1, 0, 0, 1));
    while (refClk) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      runLen(len, lvl);
      if (lvl) chk(len == 105 || len == 6, "R9", "high phase length", len, 6);
      else     chk(len == 105 || len == 4, "R9", "low phase length", len, 4);
    end
    chk(len == 4 || len == 6, "R9", "final phase length", len, 4);
    // R8: disable
    runOff(mk(1, 0, 0, 1, 0, 0, 0));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule